// File: doc/BRIEF.md
# Resolver Converter Configuration Port

This block is the serial configuration port of a resolver-to-digital converter, built as a slave on a four-wire serial bus in SPI mode 3. The host picks configuration mode with two mode-select pins and then sends a stream of bytes. Each byte is one of two kinds. If its top bit is set, the byte names a register. If its top bit is clear, it carries seven bits of data for the register named last. No command or length phase exists, so one byte stream carries both addresses and data. A register is read by sending its address byte followed by any second byte. The register contents come back on the serial output during that second byte.

The block holds a set of seven-bit threshold registers, the excitation frequency word, the control word and a sticky fault register. A data byte sent to the soft-reset address produces a one-cycle pulse and changes no configuration. Every register value is driven out in parallel for the rest of the chip. Fault bits arrive on an input and are latched. The serial pins, the sample strobe and the chip select are brought into the system clock domain through synchronizers. The system clock must run at least eight times faster than the serial clock.

Top module: `rdc_cfg_slave`

## Requirements
- R1: Bits are taken on rising serial-clock edges while chip select is low, most significant bit first, eight to a byte. Chip select high clears the bit count and drops any partial byte.
- R2: Bytes are acted on only while `mode_sel` is 2'b10. In modes 2'b00, 2'b01 and 2'b11 a byte changes no register, address or pulse, and the read data loaded for the next byte is 0x00.
- R3: A byte with bit 7 set is an address. It is latched, and it stays latched across chip-select frames. A byte with bit 7 clear writes its low seven bits to the latched address.
- R4: Registers sit at fixed addresses. Threshold k is at 0x88+k (k = 0..N_THR-1), the excitation word at 0x91, the control word at 0x92, soft reset at 0xF0 and fault at 0xFF. After an address byte, the next byte in the same frame shifts out that register, MSB first. Writable registers read with bit 7 = 0. An unmapped address, the soft-reset address and any data byte give 0x00. The first byte of a frame shifts out 0x00.
- R5: The control word resets to 0x7E and reads back with bit 7 clear.
- R6: The excitation word resets to 0x28. A write outside 0x04..0x50 leaves it unchanged.
- R7: A data byte to 0xF0 gives exactly one `soft_rst` cycle and leaves all configuration registers unchanged.
- R8: A data byte is ignored when the latched address is unmapped or is the read-only fault address 0xFF.
- R9: Fault bits OR into `fault_reg` and stay set. The register clears only on the first falling edge of `sample_n` that follows an accepted 0xFF address byte. A fall with no such read leaves it unchanged.
- R10: After reset, all thresholds and faults are 0, and `spi_miso` and `soft_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, changes after falling edges |
| mode_sel | input | 2 | Mode pins; 2'b10 selects configuration |
| sample_n | input | 1 | Sample strobe; its falling edge can clear faults |
| fault_in | input | FAULT_W | Fault bits to latch |
| thr_bus | output | N_THR*7 | Threshold k in bits [7k+6:7k] |
| exc_word | output | 7 | Excitation frequency word |
| ctrl_word | output | 7 | Control word |
| fault_reg | output | FAULT_W | Sticky fault register |
| soft_rst | output | 1 | One-cycle soft-reset pulse |

## Verification
The mode-gating properties assume that `mode_sel` is a static pin, held stable through a whole frame in the system clock domain. The bench changes it only while chip select is high. The one-cycle pulse property depends on the serial clock being much slower than `clk`, so two bytes can never complete in adjacent cycles. The bench keeps each serial half-period at six system clocks. Fault bits are applied as single-cycle pulses, away from any sample strobe.

// File: rtl/rdc_cfg_pkg.sv
package rdc_cfg_pkg;
   localparam int BYTE_W = 8;
   localparam int DATA_W = BYTE_W - 1;

   typedef enum logic [1:0] {
      MODE_POS = 2'b00,
      MODE_VEL = 2'b01,
      MODE_CFG = 2'b10,
      MODE_RSV = 2'b11
   } rdc_mode_e;

   localparam logic [BYTE_W-1:0] ADDR_THR_BASE = 8'h88;
   localparam logic [BYTE_W-1:0] ADDR_EXC      = 8'h91;
   localparam logic [BYTE_W-1:0] ADDR_CTRL     = 8'h92;
   localparam logic [BYTE_W-1:0] ADDR_SRST     = 8'hF0;
   localparam logic [BYTE_W-1:0] ADDR_FAULT    = 8'hFF;
endpackage

// File: rtl/rdc_sync.sv
module rdc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rdc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rdc_spi_port.sv
module rdc_spi_port
   import rdc_cfg_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              mosi,
   input  logic              tx_load,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_data,
   output logic              miso
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic sclk_s, cs_s, mosi_s, sclk_d;
   logic rise, fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;

   rdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   rdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
   rdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(mosi), .q(mosi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b1;
      else        sclk_d <= sclk_s;
   end

   assign rise = sclk_s & ~sclk_d & ~cs_s;
   assign fall = ~sclk_s & sclk_d & ~cs_s;

   // receive side: rising edges, MSB first
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         rx_sh      <= '0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
      end else if (cs_s) begin
         bit_cnt    <= '0;
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         if (rise) begin
            rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
               byte_valid <= 1'b1;
               byte_data  <= {rx_sh, mosi_s};
            end
         end
      end
   end

   // transmit side: falling edges, a load replaces the shifter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         miso  <= 1'b0;
      end else if (cs_s) begin
         tx_sh <= '0;
         miso  <= 1'b0;
      end else if (tx_load) begin
         tx_sh <= tx_data;
      end else if (fall) begin
         miso  <= tx_sh[BYTE_W-1];
         tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
   end
endmodule

// File: rtl/rdc_reg_bank.sv
module rdc_reg_bank
   import rdc_cfg_pkg::*;
#(
   parameter int              N_THR    = 7,
   parameter int              EXC_MIN  = 4,
   parameter int              EXC_MAX  = 80,
   parameter int              EXC_RST  = 40,
   parameter logic [DATA_W-1:0] CTRL_RST = 7'h7E,
   parameter int              FAULT_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_mode,
   input  logic                    byte_valid,
   input  logic [BYTE_W-1:0]       byte_data,
   input  logic                    sample_fall,
   input  logic [FAULT_W-1:0]      fault_in,
   output logic                    tx_load,
   output logic [BYTE_W-1:0]       tx_data,
   output logic [N_THR*DATA_W-1:0] thr_bus,
   output logic [DATA_W-1:0]       exc_word,
   output logic [DATA_W-1:0]       ctrl_word,
   output logic [FAULT_W-1:0]      fault_reg,
   output logic                    soft_rst
);
   localparam logic [BYTE_W-1:0] THR_LAST = BYTE_W'(int'(ADDR_THR_BASE) + N_THR - 1);
   localparam logic [DATA_W-1:0] EXC_LO   = DATA_W'(EXC_MIN);
   localparam logic [DATA_W-1:0] EXC_HI   = DATA_W'(EXC_MAX);

   generate
      if (N_THR < 1 || int'(ADDR_THR_BASE) + N_THR - 1 >= int'(ADDR_EXC)) begin : g_bad_thr
         $error("rdc_reg_bank: N_THR overlaps the excitation address");
      end
      if (EXC_MIN > EXC_MAX || EXC_MAX > 127 || EXC_RST < EXC_MIN || EXC_RST > EXC_MAX) begin : g_bad_exc
         $error("rdc_reg_bank: excitation limits inconsistent");
      end
      if (FAULT_W < 1 || FAULT_W > BYTE_W) begin : g_bad_fault
         $error("rdc_reg_bank: FAULT_W out of range");
      end
   endgenerate

   function automatic logic is_mapped(input logic [BYTE_W-1:0] a);
      return (a >= ADDR_THR_BASE && a <= THR_LAST) || a == ADDR_EXC ||
             a == ADDR_CTRL || a == ADDR_SRST || a == ADDR_FAULT;
   endfunction

   logic [BYTE_W-1:0]  addr_q;
   logic               addr_ok;
   logic               fault_armed;
   logic [DATA_W-1:0]  thr_q [N_THR];
   logic [DATA_W-1:0]  exc_q, ctrl_q;
   logic [FAULT_W-1:0] fault_q;
   logic               srst_q;
   logic               take_addr, wr_en;
   logic [DATA_W-1:0]  wr_data;
   logic [BYTE_W-1:0]  rd_val;

   assign take_addr = byte_valid & cfg_mode & byte_data[BYTE_W-1];
   assign wr_en     = byte_valid & cfg_mode & ~byte_data[BYTE_W-1] & addr_ok;
   assign wr_data   = byte_data[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         addr_ok <= 1'b0;
      end else if (take_addr) begin
         addr_q  <= byte_data;
         addr_ok <= is_mapped(byte_data);
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < N_THR; gi++) begin : g_thr
         localparam logic [BYTE_W-1:0] MY_ADDR = BYTE_W'(int'(ADDR_THR_BASE) + gi);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          thr_q[gi] <= '0;
            else if (wr_en && addr_q == MY_ADDR) thr_q[gi] <= wr_data;
         end
         assign thr_bus[gi*DATA_W +: DATA_W] = thr_q[gi];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_q  <= DATA_W'(EXC_RST);
         ctrl_q <= CTRL_RST;
         srst_q <= 1'b0;
      end else begin
         if (wr_en && addr_q == ADDR_EXC && wr_data >= EXC_LO && wr_data <= EXC_HI)
            exc_q <= wr_data;
         if (wr_en && addr_q == ADDR_CTRL)
            ctrl_q <= wr_data;
         srst_q <= wr_en && addr_q == ADDR_SRST;
      end
   end

   // sticky faults; a strobe fall after a fault read clears them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q     <= '0;
         fault_armed <= 1'b0;
      end else begin
         if (sample_fall && fault_armed) fault_q <= fault_in;
         else                            fault_q <= fault_q | fault_in;
         if (take_addr && byte_data == ADDR_FAULT) fault_armed <= 1'b1;
         else if (sample_fall)                     fault_armed <= 1'b0;
      end
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < N_THR; i++)
         if (byte_data == BYTE_W'(int'(ADDR_THR_BASE) + i)) rd_val = {1'b0, thr_q[i]};
      if (byte_data == ADDR_EXC)   rd_val = {1'b0, exc_q};
      if (byte_data == ADDR_CTRL)  rd_val = {1'b0, ctrl_q};
      if (byte_data == ADDR_FAULT) rd_val = BYTE_W'(fault_q);
   end

   assign tx_load   = byte_valid;
   assign tx_data   = take_addr ? rd_val : '0;
   assign exc_word  = exc_q;
   assign ctrl_word = ctrl_q;
   assign fault_reg = fault_q;
   assign soft_rst  = srst_q;
endmodule

// File: rtl/rdc_cfg_slave.sv
module rdc_cfg_slave
   import rdc_cfg_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                N_THR       = 7,
   parameter int                EXC_MIN     = 4,
   parameter int                EXC_MAX     = 80,
   parameter int                EXC_RST     = 40,
   parameter logic [DATA_W-1:0] CTRL_RST    = 7'h7E,
   parameter int                FAULT_W     = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    spi_sclk,
   input  logic                    spi_cs_n,
   input  logic                    spi_mosi,
   output logic                    spi_miso,
   input  logic [1:0]              mode_sel,
   input  logic                    sample_n,
   input  logic [FAULT_W-1:0]      fault_in,
   output logic [N_THR*DATA_W-1:0] thr_bus,
   output logic [DATA_W-1:0]       exc_word,
   output logic [DATA_W-1:0]       ctrl_word,
   output logic [FAULT_W-1:0]      fault_reg,
   output logic                    soft_rst
);
   logic              byte_valid, tx_load;
   logic [BYTE_W-1:0] byte_data, tx_data;
   logic              sample_s, sample_d, sample_fall;
   logic              cfg_mode;

   assign cfg_mode = (mode_sel == MODE_CFG);

   rdc_spi_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
      .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
      .tx_load(tx_load), .tx_data(tx_data),
      .byte_valid(byte_valid), .byte_data(byte_data), .miso(spi_miso));

   rdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sample (
      .clk(clk), .rst_n(rst_n), .d(sample_n), .q(sample_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sample_d <= 1'b1;
      else        sample_d <= sample_s;
   end
   assign sample_fall = sample_d & ~sample_s;

   rdc_reg_bank #(
      .N_THR(N_THR), .EXC_MIN(EXC_MIN), .EXC_MAX(EXC_MAX), .EXC_RST(EXC_RST),
      .CTRL_RST(CTRL_RST), .FAULT_W(FAULT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
      .byte_valid(byte_valid), .byte_data(byte_data),
      .sample_fall(sample_fall), .fault_in(fault_in),
      .tx_load(tx_load), .tx_data(tx_data),
      .thr_bus(thr_bus), .exc_word(exc_word), .ctrl_word(ctrl_word),
      .fault_reg(fault_reg), .soft_rst(soft_rst));
endmodule

// File: rtl/rdc_cfg_slave_chk.sv
module rdc_cfg_slave_chk
   import rdc_cfg_pkg::*;
#(
   parameter int N_THR   = 7,
   parameter int EXC_MIN = 4,
   parameter int EXC_MAX = 80,
   parameter int FAULT_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [1:0]              mode_sel,
   input logic [FAULT_W-1:0]      fault_in,
   input logic [N_THR*DATA_W-1:0] thr_bus,
   input logic [DATA_W-1:0]       exc_word,
   input logic [DATA_W-1:0]       ctrl_word,
   input logic [FAULT_W-1:0]      fault_reg,
   input logic                    soft_rst
);
   a_r2_gate_regs: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel != MODE_CFG |=> $stable(thr_bus) && $stable(exc_word) && $stable(ctrl_word));

   a_r2_gate_srst: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel != MODE_CFG |=> !soft_rst);

   a_r6_exc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      exc_word >= DATA_W'(EXC_MIN) && exc_word <= DATA_W'(EXC_MAX));

   a_r7_srst_single: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !soft_rst);

   a_r7_srst_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> $stable(thr_bus) && $stable(exc_word) && $stable(ctrl_word));

   a_r9_fault_captured: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (fault_reg & $past(fault_in)) == $past(fault_in));
endmodule

bind rdc_cfg_slave rdc_cfg_slave_chk #(
   .N_THR(N_THR), .EXC_MIN(EXC_MIN), .EXC_MAX(EXC_MAX), .FAULT_W(FAULT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .fault_in(fault_in),
   .thr_bus(thr_bus), .exc_word(exc_word), .ctrl_word(ctrl_word),
   .fault_reg(fault_reg), .soft_rst(soft_rst));

// File: tb/tb_rdc_cfg_slave.sv
module tb_rdc_cfg_slave;
   localparam int N_THR = 7;
   localparam int HALF  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic [1:0] mode_sel = 2'b10;
   logic sample_n = 1'b1;
   logic [7:0] fault_in = 8'h00;
   logic spi_miso, soft_rst;
   logic [N_THR*7-1:0] thr_bus;
   logic [6:0] exc_word, ctrl_word;
   logic [7:0] fault_reg;

   always #2 clk = ~clk;

   rdc_cfg_slave dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mode_sel(mode_sel),
      .sample_n(sample_n), .fault_in(fault_in), .thr_bus(thr_bus),
      .exc_word(exc_word), .ctrl_word(ctrl_word), .fault_reg(fault_reg),
      .soft_rst(soft_rst));

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   bit cmp_en = 0;

   // behavioural model
   int m_thr[N_THR];
   int m_exc = 8'h28, m_ctrl = 8'h7E, m_fault = 0;
   int m_addr = 0;
   bit m_ok = 0, m_arm = 0;
   int exp_tx = 0;
   int srst_exp = 0, srst_seen = 0;

   task automatic chk(string req, string what, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic bit mapped(int a);
      return (a >= 8'h88 && a < 8'h88 + N_THR) || a == 8'h91 || a == 8'h92 ||
             a == 8'hF0 || a == 8'hFF;
   endfunction

   function automatic int model_read(int a);
      if (a >= 8'h88 && a < 8'h88 + N_THR) return m_thr[a - 8'h88];
      if (a == 8'h91) return m_exc;
      if (a == 8'h92) return m_ctrl;
      if (a == 8'hFF) return m_fault;
      return 0;
   endfunction

   task automatic model_apply(logic [7:0] b);
      if (mode_sel != 2'b10) begin exp_tx = 0; return; end
      if (b[7]) begin
         m_addr = int'(b);
         m_ok   = mapped(m_addr);
         exp_tx = model_read(m_addr);
         if (b == 8'hFF) m_arm = 1;
      end else begin
         exp_tx = 0;
         if (m_ok) begin
            if (m_addr >= 8'h88 && m_addr < 8'h88 + N_THR) m_thr[m_addr - 8'h88] = int'(b);
            else if (m_addr == 8'h91) begin
               if (b >= 8'h04 && b <= 8'h50) m_exc = int'(b);
            end
            else if (m_addr == 8'h92) m_ctrl = int'(b);
            else if (m_addr == 8'hF0) srst_exp++;
         end
      end
   endtask

   // one chip-select frame; miso of each byte checked against the model (R4)
   task automatic frame(input logic [7:0] bs[$]);
      logic [7:0] got;
      cmp_en = 0;
      @(negedge clk);
      spi_cs_n = 1'b0;
      exp_tx = 0;
      wait_clk(HALF);
      foreach (bs[j]) begin
         for (int k = 7; k >= 0; k--) begin
            spi_sclk = 1'b0;
            spi_mosi = bs[j][k];
            wait_clk(HALF);
            got[k] = spi_miso;
            spi_sclk = 1'b1;
            wait_clk(HALF);
         end
         chk("R4", $sformatf("miso byte %0d", j), int'(got), exp_tx);
         model_apply(bs[j]);
      end
      spi_cs_n = 1'b1;
      wait_clk(10);
      cmp_en = 1;
   endtask

   task automatic partial(int nbits);
      cmp_en = 0;
      @(negedge clk);
      spi_cs_n = 1'b0;
      wait_clk(HALF);
      for (int k = 0; k < nbits; k++) begin
         spi_sclk = 1'b0;
         spi_mosi = (k % 4 == 0);
         wait_clk(HALF);
         spi_sclk = 1'b1;
         wait_clk(HALF);
      end
      spi_cs_n = 1'b1;
      wait_clk(10);
      cmp_en = 1;
   endtask

   task automatic strobe();
      cmp_en = 0;
      @(negedge clk);
      sample_n = 1'b0;
      wait_clk(8);
      if (m_arm) begin m_fault = 0; m_arm = 0; end
      sample_n = 1'b1;
      wait_clk(8);
      cmp_en = 1;
   endtask

   task automatic inject(logic [7:0] v);
      cmp_en = 0;
      @(negedge clk);
      fault_in = v;
      @(negedge clk);
      fault_in = 8'h00;
      wait_clk(3);
      m_fault = m_fault | int'(v);
      cmp_en = 1;
   endtask

   // compare against the model on every clock while idle
   always @(negedge clk) begin
      if (soft_rst) srst_seen++;
      if (cmp_en && rst_n && !finished) begin
         bit ok = 1;
         for (int i = 0; i < N_THR; i++)
            if (int'(thr_bus[i*7 +: 7]) != m_thr[i]) ok = 0;
         n_chk++;
         if (!ok || int'(exc_word) != m_exc || int'(ctrl_word) != m_ctrl ||
             int'(fault_reg) != m_fault) begin
            n_bad++;
            $display("FAIL R3 per-clock compare: got thr=%h exc=%h ctrl=%h fault=%h expected exc=%h ctrl=%h fault=%h",
                     thr_bus, exc_word, ctrl_word, fault_reg, m_exc, m_ctrl, m_fault);
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      foreach (m_thr[i]) m_thr[i] = 0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);

      chk("R10", "thr_bus reset", int'(thr_bus != 0), 0);
      chk("R10", "fault reset", int'(fault_reg), 0);
      chk("R10", "miso reset", int'(spi_miso), 0);
      chk("R10", "soft_rst reset", int'(soft_rst), 0);
      chk("R5", "ctrl reset", int'(ctrl_word), 8'h7E);
      chk("R6", "exc reset", int'(exc_word), 8'h28);
      cmp_en = 1;

      frame('{8'h92, 8'hFF});                    // R5 readback of reset control

      for (int i = 0; i < N_THR; i++) begin       // R3 address persists across frames
         frame('{8'(8'h88 + i)});
         frame('{8'(8'h10 + 3 * i)});
         frame('{8'(8'h88 + i), 8'hFF});
      end
      chk("R3", "thr6 write", int'(thr_bus[6*7 +: 7]), 8'h10 + 18);

      frame('{8'h91, 8'h50});
      chk("R6", "exc upper bound", int'(exc_word), 8'h50);
      frame('{8'h51});
      chk("R6", "exc above range", int'(exc_word), 8'h50);
      frame('{8'h03});
      chk("R6", "exc below range", int'(exc_word), 8'h50);
      frame('{8'h04});
      chk("R6", "exc lower bound", int'(exc_word), 8'h04);

      frame('{8'h92, 8'h11, 8'h92, 8'hFF});
      chk("R3", "ctrl write", int'(ctrl_word), 8'h11);

      frame('{8'hF0, 8'h00});
      chk("R7", "soft reset pulse count", srst_seen, 1);
      chk("R7", "ctrl kept over soft reset", int'(ctrl_word), 8'h11);
      chk("R7", "exc kept over soft reset", int'(exc_word), 8'h04);

      frame('{8'h80, 8'h33});                    // R8 unmapped target
      chk("R8", "data to unmapped", int'(thr_bus[6:0]), 8'h10);
      frame('{8'h80, 8'hFF});
      frame('{8'hFF, 8'h22});                    // R8 read-only fault
      chk("R8", "data to fault reg", int'(fault_reg), 0);

      mode_sel = 2'b00;                           // R2 position mode
      frame('{8'h89, 8'h55, 8'h89, 8'hFF});
      chk("R2", "thr1 in mode 00", int'(thr_bus[13:7]), 8'h13);
      mode_sel = 2'b01;
      frame('{8'hF0, 8'h00});
      chk("R2", "soft reset in mode 01", srst_seen, 1);
      mode_sel = 2'b11;
      frame('{8'h92, 8'h05});
      chk("R2", "ctrl in mode 11", int'(ctrl_word), 8'h11);
      mode_sel = 2'b10;

      partial(5);                                 // R1 partial byte discarded
      frame('{8'h89, 8'h2A});
      chk("R1", "byte after partial", int'(thr_bus[13:7]), 8'h2A);
      partial(3);
      frame('{8'h89, 8'hFF});

      strobe();                                   // R9 disarm
      inject(8'h05);
      chk("R9", "fault latched", int'(fault_reg), 8'h05);
      inject(8'h40);
      chk("R9", "fault sticky", int'(fault_reg), 8'h45);
      strobe();
      chk("R9", "strobe without read", int'(fault_reg), 8'h45);
      frame('{8'hFF, 8'hFF});
      chk("R9", "fault after read", int'(fault_reg), 8'h45);
      strobe();
      chk("R9", "fault cleared", int'(fault_reg), 8'h00);

      chk("R7", "total soft reset pulses", srst_seen, srst_exp);
      cmp_en = 0;
      wait_clk(4);
      summary();
   end
endmodule